// File: doc/BRIEF.md
# Dual Recirculating Static Shift Register

This block holds two independent serial shift registers of one fixed length, LEN, which is 128 or 132 bits. Both run from one shared clock. Each register has its own control input, serial data input and serial data output. On every rising clock edge each register moves its contents one position toward the output end. The bit that enters the head is chosen by that register's control. With the control low, the register feeds back the bit at its output end, so the contents circulate. With the control high, the register takes the external data bit, so new data is written.

Storage is static. If the clock stops at any level, for any length of time, the contents, the outputs and the position count stay as they are. A position counter counts clock edges modulo LEN. It marks where a revolution starts. A synchronous clear, active high, empties both registers and the counter. The clear is for simulation start-up only.

Top module: `dual_recirc_shreg`

## Requirements
- R1: The two registers are independent. Each control bit and data bit acts only on its own register. One register can be written while the other circulates, and the circulating one keeps its contents.
- R2: LEN sets the register length, with 128 or 132 as the supported values and 128 as the default. A bit written into a 132-bit instance appears at the output 131 edges after its write edge.
- R3: Control value 0 means circulate. At a rising edge the bit shown on `dout` enters the head, and `din` has no effect on the contents whatever its value.
- R4: Control value 1 means write. At a rising edge the bit on `din` enters the head: a 1 stores a 1 and a 0 stores a 0.
- R5: Each rising edge moves every stored bit one place toward the output. `dout` shows the end position. A bit taken in at edge k is shown on `dout` from edge k+LEN-1 until edge k+LEN.
- R6: While a register circulates, its `dout` sequence repeats with a period of LEN edges, and its contents are unchanged after every full revolution.
- R7: With no rising edge, `dout` and `pos` hold their values for any length of time, whatever `mode` and `din` do.
- R8: `mode` and `din` are sampled only at the rising edge. Changes between edges have no effect except through the value present at the edge.
- R9: When `clr` is 1 at a rising edge, every stored bit becomes 0 and `pos` becomes 0. The clear takes precedence over `mode`.
- R10: `pos` counts rising edges modulo LEN. It goes up by 1 at each edge and returns from LEN-1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock; rising edge is active |
| clr | input | 1 | Synchronous clear, active high, simulation start-up only |
| mode | input | NUM_REGS | Per-register control: 0 circulate, 1 write (bit i drives register i) |
| din | input | NUM_REGS | Per-register serial data input |
| dout | output | NUM_REGS | Per-register serial output, the bit at the end position |
| pos | output | clog2(LEN) | Edge count modulo LEN |

## Verification
The value on `mode` and `din` at edge k decides the head bit in the cycle after k. That bit reaches `dout` only after edge k+LEN-1, and `pos` changes at every edge. For this reason the scoreboard model is stepped exactly once per rising edge, and both outputs are compared at the following falling edge. The one-cycle effect on the head is checked by properties. The full latency is checked at the ports for both lengths, by sampling one edge before the written bit is due and on the edge where it is due. For the clock-stall case the outputs are captured and then compared again after a long gap in which the inputs keep changing.

// File: rtl/drs_pkg.sv
package drs_pkg;

    // Per-register control meaning
    typedef enum logic {
        DRS_RECIRC = 1'b0,
        DRS_WRITE  = 1'b1
    } drs_mode_e;

    // Sampled control for one register
    typedef struct packed {
        drs_mode_e mode;
        logic      din;
    } drs_ctrl_t;

    // Choose the bit that enters the head of a register
    function automatic logic drs_pick(drs_ctrl_t c, logic tail);
        return (c.mode == DRS_WRITE) ? c.din : tail;
    endfunction

    // Counter width for a modulo-n count
    function automatic int unsigned drs_cnt_w(int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/drs_feed_sel.sv
module drs_feed_sel
    import drs_pkg::*;
(
    input  drs_ctrl_t ctrl,
    input  logic      tail,
    output logic      feed
);
    assign feed = drs_pick(ctrl, tail);
endmodule

// File: rtl/drs_lane.sv
module drs_lane
    import drs_pkg::*;
#(
    parameter int unsigned LEN = 128
) (
    input  logic      clk,
    input  logic      clr,
    input  drs_ctrl_t ctrl,
    output logic      dout,
    output logic      head
);
    localparam int unsigned TOP = LEN - 1;

    logic [TOP:0] stor;
    logic         feed;

    drs_feed_sel u_sel (
        .ctrl (ctrl),
        .tail (stor[TOP]),
        .feed (feed)
    );

    // Index 0 is the head, index TOP is the output end
    always_ff @(posedge clk) begin
        if (clr) begin
            stor <= '0;
        end else begin
            stor <= {stor[TOP-1:0], feed};
        end
    end

    assign dout = stor[TOP];
    assign head = stor[0];
endmodule

// File: rtl/drs_pos_counter.sv
module drs_pos_counter #(
    parameter int unsigned LEN   = 128,
    parameter int unsigned POS_W = 7
) (
    input  logic             clk,
    input  logic             clr,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] LAST = POS_W'(LEN - 1);

    always_ff @(posedge clk) begin
        if (clr || pos == LAST) begin
            pos <= '0;
        end else begin
            pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/dual_recirc_shreg.sv
module dual_recirc_shreg
    import drs_pkg::*;
#(
    parameter int unsigned LEN      = 128,
    parameter int unsigned NUM_REGS = 2,
    localparam int unsigned POS_W   = drs_cnt_w(LEN)
) (
    input  logic                clk,
    input  logic                clr,
    input  logic [NUM_REGS-1:0] mode,
    input  logic [NUM_REGS-1:0] din,
    output logic [NUM_REGS-1:0] dout,
    output logic [POS_W-1:0]    pos
);
    logic [NUM_REGS-1:0] head_bit;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_lane
        drs_ctrl_t ctrl;
        assign ctrl.mode = drs_mode_e'(mode[g]);
        assign ctrl.din  = din[g];

        drs_lane #(.LEN(LEN)) u_lane (
            .clk  (clk),
            .clr  (clr),
            .ctrl (ctrl),
            .dout (dout[g]),
            .head (head_bit[g])
        );
    end

    drs_pos_counter #(.LEN(LEN), .POS_W(POS_W)) u_pos (
        .clk (clk),
        .clr (clr),
        .pos (pos)
    );
endmodule

// File: rtl/drs_chk.sv
module drs_chk #(
    parameter int unsigned LEN      = 128,
    parameter int unsigned NUM_REGS = 2,
    parameter int unsigned POS_W    = 7
) (
    input logic                clk,
    input logic                clr,
    input logic [NUM_REGS-1:0] mode,
    input logic [NUM_REGS-1:0] din,
    input logic [NUM_REGS-1:0] dout,
    input logic [NUM_REGS-1:0] head,
    input logic [POS_W-1:0]    pos
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        // Circulate: the output bit re-enters at the head (R3, R1)
        assert_recirc_R3: assert property (@(posedge clk) disable iff (clr)
            !mode[g] |=> head[g] == $past(dout[g]));
        // Write: the data bit enters at the head (R4, R1)
        assert_write_R4: assert property (@(posedge clk) disable iff (clr)
            mode[g] |=> head[g] == $past(din[g]));
    end

    // Leaving clear: both registers empty and count at zero
    assert_clear_R9: assert property (@(posedge clk) disable iff (clr)
        $fell(clr) |-> (dout == '0 && pos == '0));

    // Count advances by one and wraps at LEN-1
    assert_pos_wrap_R10: assert property (@(posedge clk) disable iff (clr)
        !$past(clr) |-> pos == (($past(pos) == POS_W'(LEN - 1)) ? POS_W'(0)
                                                                : POS_W'($past(pos) + 1'b1)));
endmodule

bind dual_recirc_shreg drs_chk #(
    .LEN(LEN), .NUM_REGS(NUM_REGS), .POS_W(POS_W)
) u_chk (
    .clk  (clk),
    .clr  (clr),
    .mode (mode),
    .din  (din),
    .dout (dout),
    .head (head_bit),
    .pos  (pos)
);

// File: tb/tb_dual_recirc_shreg.sv
`timescale 1ns/1ps
module tb_dual_recirc_shreg;
    localparam int unsigned LEN = 128;
    localparam int unsigned NR  = 2;
    localparam int unsigned PW  = $clog2(LEN);
    localparam int unsigned L2  = 132;
    localparam int unsigned PW2 = $clog2(L2);

    logic clk = 1'b0, clr = 1'b1, clk_run = 1'b1;
    logic [NR-1:0] mode = '0, din = '0;
    logic [NR-1:0] dout;
    logic [PW-1:0] pos;
    logic [NR-1:0] mode2 = '0, din2 = '0;
    logic [NR-1:0] dout2;
    logic [PW2-1:0] pos2;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    typedef struct { logic [NR-1:0] d; logic [PW-1:0] p; } exp_t;
    exp_t exp_q[$];
    bit q0[$], q1[$];
    int epos = 0;
    bit pat1[LEN];
    bit rev[LEN];

    dual_recirc_shreg #(.LEN(LEN), .NUM_REGS(NR)) dut (
        .clk(clk), .clr(clr), .mode(mode), .din(din), .dout(dout), .pos(pos));
    dual_recirc_shreg #(.LEN(L2), .NUM_REGS(NR)) dut132 (
        .clk(clk), .clr(clr), .mode(mode2), .din(din2), .dout(dout2), .pos(pos2));

    initial forever begin
        #2;
        if (clk_run) clk = ~clk;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic report();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Reference model step for one rising edge (front of queue = output end)
    task automatic model_step(logic [NR-1:0] m, logic [NR-1:0] d);
        bit b0, b1;
        exp_t e;
        b0 = m[0] ? d[0] : q0[0];
        b1 = m[1] ? d[1] : q1[0];
        void'(q0.pop_front()); q0.push_back(b0);
        void'(q1.pop_front()); q1.push_back(b1);
        epos = (epos == LEN - 1) ? 0 : epos + 1;
        e.d = {q1[0], q0[0]};
        e.p = PW'(epos);
        exp_q.push_back(e);
    endtask

    task automatic do_clear();
        exp_t e;
        @(negedge clk);
        clr = 1'b1; mode = '0; din = '0;
        @(posedge clk);
        q0.delete(); q1.delete();
        for (int i = 0; i < LEN; i++) begin q0.push_back(1'b0); q1.push_back(1'b0); end
        epos = 0;
        e.d = '0; e.p = '0;
        exp_q.push_back(e);
    endtask

    // Driver: set inputs away from the edge, then step the model at the edge
    task automatic cyc(logic [NR-1:0] m, logic [NR-1:0] d);
        @(negedge clk);
        clr = 1'b0; mode = m; din = d;
        @(posedge clk);
        model_step(m, d);
    endtask

    // Monitor: compare outputs half a cycle after each edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check("R3/R4/R5 dout", 32'(dout), 32'(e.d));
            check("R10 pos", 32'(pos), 32'(e.p));
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
        end
    end

    initial begin
        int mis;
        logic [NR-1:0] hd;
        logic [PW-1:0] hp;

        // R9: clear state
        do_clear();
        @(negedge clk); #0.5;
        check("R9 dout after clear", 32'(dout), 0);
        check("R9 pos after clear", 32'(pos), 0);

        // R4: write random patterns into both registers
        for (int i = 0; i < LEN; i++) begin
            logic [NR-1:0] r;
            r = NR'($urandom);
            pat1[i] = r[1];
            cyc(2'b11, r);
        end

        // R1: write lane 0, lane 1 circulates with noise on its input (R3)
        mis = 0;
        for (int m = 1; m <= LEN; m++) begin
            cyc(2'b01, NR'($urandom));
            #1;
            if (dout[1] !== pat1[m % LEN]) mis++;
        end
        check("R1 lane1 kept while lane0 written", 32'(mis), 0);

        // R8: inputs glitch between edges, only the edge value counts
        for (int i = 0; i < 8; i++) begin
            logic [NR-1:0] r;
            r = NR'($urandom);
            @(negedge clk);
            mode = 2'b11; din = ~r; #0.4; din = r; #0.4; din = ~r; #0.4; din = r;
            @(posedge clk);
            model_step(2'b11, r);
        end

        // R6: circulate several revolutions with random input noise (R3)
        for (int i = 0; i < LEN; i++) begin
            cyc(2'b00, NR'($urandom)); #1; rev[i] = dout[0];
        end
        for (int k = 0; k < 2; k++) begin
            mis = 0;
            for (int i = 0; i < LEN; i++) begin
                cyc(2'b00, NR'($urandom)); #1;
                if (dout[0] !== rev[i]) mis++;
            end
            check("R6 revolution repeats", 32'(mis), 0);
        end

        // R7: clock stall with toggling inputs
        @(negedge clk); #0.5;
        clk_run = 1'b0;
        hd = dout; hp = pos;
        for (int i = 0; i < 40; i++) begin
            mode = NR'($urandom); din = NR'($urandom); #7;
        end
        check("R7 dout held in stall", 32'(dout), 32'(hd));
        check("R7 pos held in stall", 32'(pos), 32'(hp));
        mode = '0; din = NR'($urandom);
        clk_run = 1'b1;
        @(posedge clk);
        model_step(2'b00, din);

        // R5 and R2: latency of a single written 1 in both lengths
        do_clear();
        @(negedge clk);
        clr = 1'b0; mode = 2'b01; din = 2'b01; mode2 = 2'b01; din2 = 2'b01;
        @(posedge clk);
        model_step(2'b01, 2'b01);
        for (int e = 1; e <= int'(L2) - 1; e++) begin
            @(negedge clk);
            mode = '0; din = '0; mode2 = '0; din2 = '0;
            @(posedge clk);
            model_step(2'b00, 2'b00);
            #1;
            if (e == int'(LEN) - 2) check("R5 not yet at LEN-2", 32'(dout[0]), 0);
            if (e == int'(LEN) - 1) check("R5 due at LEN-1", 32'(dout[0]), 1);
            if (e == int'(L2) - 2) check("R2 len132 not yet", 32'(dout2[0]), 0);
            if (e == int'(L2) - 1) check("R2 len132 due", 32'(dout2[0]), 1);
        end
        check("R2 len132 other lane empty", 32'(dout2[1]), 0);

        @(negedge clk); #0.5;
        report();
    end
endmodule